// File: doc/BRIEF.md
# Eight-Port Periodic Transmit Trigger Scheduler

The scheduler decides when a frame handler serving eight serial ports starts each transmission. A single free-running time counter is shared by all ports. Every port has its own compare value, cycle period, enable bit and three sticky status bits. The handler receives a one-cycle trigger per port and answers on a per-port completion line once the reply for that port is in.

The host configures the block through a small register bus. In start-up (manual) mode the timer never fires. A transmission begins only when the host sets the port's bit in the send-request register. After the host has programmed each port's compare value and period, it switches the block to operational mode. From then on, a counter match alone triggers the port, and the compare value then steps forward by the period.

Each triggered exchange stays pending until the completion line answers or a per-exchange reply timeout runs out. Either outcome sets a status bit and can raise the host interrupt.

Top module: `cyc_trig_sched`

## Requirements
- R1: After reset the shared counter counts up by one every clock from zero. Its value reads back at address 0x06.
- R2: In operational mode (address 0x00 bit 0 = 1), take an enabled, idle port whose compare value equals the counter. Its trigger output goes high in the next cycle, for exactly one cycle.
- R3: On every timer match of a port, that port's compare register (address 0x20+4*p) grows by its period register (address 0x21+4*p), modulo 2^16.
- R4: In manual mode (bit 0 = 0) counter matches never trigger. Writing a 1 to bit p of address 0x02 triggers port p in the next cycle if it is enabled and idle. Writes to 0x02 have no effect in operational mode.
- R5: A port whose enable bit (bit 0 of address 0x22+4*p) is 0 never triggers.
- R6: A trigger makes the port pending. A completion pulse while pending ends the exchange and sets done status (address 0x03, bit p). A completion pulse while idle is ignored.
- R7: On a trigger, the timeout register value L (address 0x01) is loaded for that port. If no completion arrives, the exchange ends L+1 cycles after the trigger edge and sets timeout status (address 0x04, bit p). A completion in that same cycle wins and sets done instead.
- R8: A trigger that comes due (by timer or by request) while the port is pending is dropped. It sets the port's sticky overrun status (address 0x05, bit p) instead.
- R9: Status bits are cleared by writing 1 to them. A set and a clear in the same cycle leave the bit set.
- R10: The interrupt output is high exactly when some port that is enabled has one of its three status bits set.
- R11: Reset clears mode, timeout, enables, compare, period, status and triggers. Unused addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 6 | Register address for write and read |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for host_addr (combinational) |
| fh_done_i | input | 8 | Per-port completion pulses from the frame handler |
| fh_trig_o | output | 8 | Per-port one-cycle transmit triggers |
| irq_o | output | 1 | Host interrupt |

## Verification
The bench first drives the scheduler in manual mode with random send requests, random completion pulses and random status clears. This shows whether requests are honoured, dropped as overruns, or gated by the enable bit. It then runs in operational mode with a different random period per port and the same random reply traffic. That phase separates correct compare stepping from drift, and it tells timer triggers apart from ignored requests. Directed sequences then pin down exact edges of behaviour. One places the timeout expiry on an exact cycle. Another lands a completion in the expiry cycle, where done must win. A third sends a stray completion to an idle port. The last disables ports that still hold status, which must drop the interrupt.

// File: rtl/cts_pkg.sv
package cts_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_MODE  = 6'h00;
  localparam logic [ADDR_W-1:0] A_TLIM  = 6'h01;
  localparam logic [ADDR_W-1:0] A_KICK  = 6'h02;
  localparam logic [ADDR_W-1:0] A_SDONE = 6'h03;
  localparam logic [ADDR_W-1:0] A_STMO  = 6'h04;
  localparam logic [ADDR_W-1:0] A_SOVR  = 6'h05;
  localparam logic [ADDR_W-1:0] A_COUNT = 6'h06;

  localparam logic [1:0] F_CMP = 2'd0;
  localparam logic [1:0] F_PER = 2'd1;
  localparam logic [1:0] F_EN  = 2'd2;

  typedef struct packed {
    logic ovr;
    logic tmo;
    logic done;
  } slot_st_t;
endpackage

// File: rtl/cts_regs.sv
module cts_regs
  import cts_pkg::*;
#(
  parameter int NPORT = 8,
  parameter int TW    = 16,
  parameter int DW    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic              mode,
  output logic [TW-1:0]     tlim,
  output logic [NPORT-1:0]  en,
  output logic [NPORT-1:0]  kick,
  output logic [NPORT-1:0]  clr_done,
  output logic [NPORT-1:0]  clr_tmo,
  output logic [NPORT-1:0]  clr_ovr,
  output logic [NPORT-1:0]  cmp_we,
  output logic [NPORT-1:0]  per_we
);
  localparam int PIW = (NPORT > 1) ? $clog2(NPORT) : 1;

  logic             mode_d;
  logic [TW-1:0]    tlim_d;
  logic [NPORT-1:0] en_d;
  logic             glob_we, port_we;
  logic [PIW-1:0]   pidx;
  logic [1:0]       fld;

  assign glob_we = we & ~addr[ADDR_W-1];
  assign port_we = we &  addr[ADDR_W-1];
  assign pidx    = addr[PIW+1:2];
  assign fld     = addr[1:0];

  always_comb begin
    mode_d   = mode;
    tlim_d   = tlim;
    en_d     = en;
    kick     = '0;
    clr_done = '0;
    clr_tmo  = '0;
    clr_ovr  = '0;
    cmp_we   = '0;
    per_we   = '0;
    if (glob_we) begin
      case (addr)
        A_MODE:  mode_d   = wdata[0];
        A_TLIM:  tlim_d   = wdata[TW-1:0];
        A_KICK:  kick     = wdata[NPORT-1:0];
        A_SDONE: clr_done = wdata[NPORT-1:0];
        A_STMO:  clr_tmo  = wdata[NPORT-1:0];
        A_SOVR:  clr_ovr  = wdata[NPORT-1:0];
        default: ;
      endcase
    end
    for (int p = 0; p < NPORT; p++) begin
      if (port_we && pidx == PIW'(p)) begin
        case (fld)
          F_CMP:   cmp_we[p] = 1'b1;
          F_PER:   per_we[p] = 1'b1;
          F_EN:    en_d[p]   = wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= 1'b0;
      tlim <= '0;
      en   <= '0;
    end else if (we) begin
      mode <= mode_d;
      tlim <= tlim_d;
      en   <= en_d;
    end
  end
endmodule

// File: rtl/cts_slot.sv
module cts_slot
  import cts_pkg::*;
#(
  parameter int CW = 16,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          op_mode,
  input  logic          en,
  input  logic [TW-1:0] tlim,
  input  logic          kick,
  input  logic          done_i,
  input  logic          cmp_we,
  input  logic          per_we,
  input  logic [CW-1:0] wval,
  input  slot_st_t      clr,
  output logic          trig,
  output logic [CW-1:0] cmp,
  output logic [CW-1:0] per,
  output logic          pend,
  output slot_st_t      st
);
  logic          due_tmr, due_man, due, fire, fin_ok, fin_to;
  logic [CW-1:0] cmp_d, per_d;
  logic [TW-1:0] tc, tc_d;
  logic          pend_d;
  slot_st_t      set_v, st_d;

  always_comb begin
    due_tmr = op_mode & en & (cnt == cmp);
    due_man = ~op_mode & en & kick;
    due     = due_tmr | due_man;
    fire    = due & ~pend;
    fin_ok  = pend & done_i;
    fin_to  = pend & ~done_i & (tc == '0);

    cmp_d = cmp;
    if (cmp_we)       cmp_d = wval;
    else if (due_tmr) cmp_d = cmp + per;
    per_d = per_we ? wval : per;

    pend_d = pend;
    tc_d   = tc;
    if (fire) begin
      pend_d = 1'b1;
      tc_d   = tlim;
    end else if (fin_ok | fin_to) begin
      pend_d = 1'b0;
    end else if (pend) begin
      tc_d = tc - TW'(1);
    end

    set_v.ovr  = due & pend;
    set_v.tmo  = fin_to;
    set_v.done = fin_ok;
    st_d       = set_v | (st & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp  <= '0;
      per  <= '0;
      pend <= 1'b0;
      tc   <= '0;
      st   <= '0;
      trig <= 1'b0;
    end else begin
      cmp  <= cmp_d;
      per  <= per_d;
      pend <= pend_d;
      tc   <= tc_d;
      st   <= st_d;
      trig <= fire;
    end
  end

  // R2: trigger is a single-cycle pulse
  p_trig_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);
  // R2: a trigger issued in operational mode comes from a counter match
  p_timer_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && $past(op_mode)) |-> ($past(cnt) == $past(cmp)));
  // R5: only an enabled port triggers
  p_en_gates_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(en));
  // R6: done status only rises out of a pending exchange
  p_done_from_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st.done) |-> $past(pend));
  // R7: timeout only rises when pending and no completion came
  p_tmo_from_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st.tmo) |-> ($past(pend) && !$past(done_i)));
  // R8: an overrun drops the trigger
  p_ovr_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st.ovr) |-> !trig);
endmodule

// File: rtl/cyc_trig_sched.sv
module cyc_trig_sched
  import cts_pkg::*;
#(
  parameter int NPORT = 8,
  parameter int CW    = 16,
  parameter int TW    = 16,
  parameter int DW    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  input  logic [NPORT-1:0]  fh_done_i,
  output logic [NPORT-1:0]  fh_trig_o,
  output logic              irq_o
);
  localparam int PIW = (NPORT > 1) ? $clog2(NPORT) : 1;

  logic             mode;
  logic [TW-1:0]    tlim;
  logic [NPORT-1:0] en, kick, clr_done, clr_tmo, clr_ovr, cmp_we, per_we;
  logic [NPORT-1:0] s_done, s_tmo, s_ovr, pend;
  logic [CW-1:0]    cnt, cnt_d;
  logic [CW-1:0]    cmp_v [NPORT];
  logic [CW-1:0]    per_v [NPORT];
  logic [PIW-1:0]   pidx;

  cts_regs #(.NPORT(NPORT), .TW(TW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(host_we), .addr(host_addr), .wdata(host_wdata),
    .mode(mode), .tlim(tlim), .en(en), .kick(kick),
    .clr_done(clr_done), .clr_tmo(clr_tmo), .clr_ovr(clr_ovr),
    .cmp_we(cmp_we), .per_we(per_we)
  );

  assign cnt_d = cnt + CW'(1);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_slot
    slot_st_t clr_p, st_p;
    assign clr_p.ovr  = clr_ovr[p];
    assign clr_p.tmo  = clr_tmo[p];
    assign clr_p.done = clr_done[p];
    cts_slot #(.CW(CW), .TW(TW)) u_slot (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .op_mode(mode), .en(en[p]),
      .tlim(tlim), .kick(kick[p]), .done_i(fh_done_i[p]),
      .cmp_we(cmp_we[p]), .per_we(per_we[p]), .wval(host_wdata[CW-1:0]),
      .clr(clr_p), .trig(fh_trig_o[p]), .cmp(cmp_v[p]), .per(per_v[p]),
      .pend(pend[p]), .st(st_p)
    );
    assign s_done[p] = st_p.done;
    assign s_tmo[p]  = st_p.tmo;
    assign s_ovr[p]  = st_p.ovr;
  end

  assign irq_o = |((s_done | s_tmo | s_ovr) & en);

  assign pidx = host_addr[PIW+1:2];
  always_comb begin
    host_rdata = '0;
    if (host_addr[ADDR_W-1]) begin
      if ({1'b0, pidx} < (PIW+1)'(NPORT)) begin
        case (host_addr[1:0])
          F_CMP:   host_rdata[CW-1:0] = cmp_v[pidx];
          F_PER:   host_rdata[CW-1:0] = per_v[pidx];
          F_EN:    host_rdata[0]      = en[pidx];
          default: ;
        endcase
      end
    end else begin
      case (host_addr)
        A_MODE:  host_rdata[0]       = mode;
        A_TLIM:  host_rdata[TW-1:0]  = tlim;
        A_SDONE: host_rdata[NPORT-1:0] = s_done;
        A_STMO:  host_rdata[NPORT-1:0] = s_tmo;
        A_SOVR:  host_rdata[NPORT-1:0] = s_ovr;
        A_COUNT: host_rdata[CW-1:0]  = cnt;
        default: ;
      endcase
    end
  end

  // R1: counter steps by one every clock
  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt == CW'($past(cnt) + CW'(1))));
  // R10: no enabled port means no interrupt
  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq_o);
  // R6: a port that is idle produces no trigger out of a finished exchange
  p_trig_sets_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fh_trig_o != '0) |-> ((fh_trig_o & ~pend) == '0));
endmodule

// File: tb/sim_cyc_trig_sched.sv
module sim_cyc_trig_sched;
  import cts_pkg::*;
  localparam int NP = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        we;
  logic [5:0]  addr;
  logic [15:0] wdata, rdata;
  logic [7:0]  done_i, trig_o;
  logic        irq_o;

  always #4 clk = ~clk;

  cyc_trig_sched u0 (
    .clk(clk), .rst_n(rst_n), .host_we(we), .host_addr(addr), .host_wdata(wdata),
    .host_rdata(rdata), .fh_done_i(done_i), .fh_trig_o(trig_o), .irq_o(irq_o)
  );

  int n_chk = 0;
  int n_err = 0;

  // bench model, updated from the requirements
  logic [15:0] m_cnt, m_lim;
  logic        m_mode;
  logic [7:0]  m_en, m_pend, m_sd, m_st, m_so, m_trig;
  logic [15:0] m_cmp [NP];
  logic [15:0] m_per [NP];
  logic [15:0] m_tc  [NP];

  always @(posedge clk or negedge rst_n) begin : model
    logic [7:0] kv, cdv, ctv, cov;
    logic dt, dm, fi, sdset, stset;
    if (!rst_n) begin
      m_cnt <= '0; m_lim <= '0; m_mode <= 1'b0;
      m_en <= '0; m_pend <= '0; m_sd <= '0; m_st <= '0; m_so <= '0; m_trig <= '0;
      for (int p = 0; p < NP; p++) begin
        m_cmp[p] <= '0; m_per[p] <= '0; m_tc[p] <= '0;
      end
    end else begin
      kv  = (we && addr == A_KICK)  ? wdata[7:0] : 8'h0;
      cdv = (we && addr == A_SDONE) ? wdata[7:0] : 8'h0;
      ctv = (we && addr == A_STMO)  ? wdata[7:0] : 8'h0;
      cov = (we && addr == A_SOVR)  ? wdata[7:0] : 8'h0;
      m_cnt <= m_cnt + 16'd1;
      if (we && addr == A_MODE) m_mode <= wdata[0];
      if (we && addr == A_TLIM) m_lim  <= wdata;
      for (int p = 0; p < NP; p++) begin
        dt = m_mode && m_en[p] && (m_cnt == m_cmp[p]);
        dm = !m_mode && m_en[p] && kv[p];
        fi = (dt || dm) && !m_pend[p];
        m_trig[p] <= fi;
        if (we && addr == 6'(32 + 4*p)) m_cmp[p] <= wdata;
        else if (dt) m_cmp[p] <= m_cmp[p] + m_per[p];
        if (we && addr == 6'(33 + 4*p)) m_per[p] <= wdata;
        if (we && addr == 6'(34 + 4*p)) m_en[p] <= wdata[0];
        sdset = 1'b0; stset = 1'b0;
        if (fi) begin
          m_pend[p] <= 1'b1; m_tc[p] <= m_lim;
        end else if (m_pend[p]) begin
          if (done_i[p]) begin m_pend[p] <= 1'b0; sdset = 1'b1; end
          else if (m_tc[p] == 16'd0) begin m_pend[p] <= 1'b0; stset = 1'b1; end
          else m_tc[p] <= m_tc[p] - 16'd1;
        end
        m_sd[p] <= sdset | (m_sd[p] & !cdv[p]);
        m_st[p] <= stset | (m_st[p] & !ctv[p]);
        m_so[p] <= ((dt || dm) && m_pend[p]) | (m_so[p] & !cov[p]);
      end
    end
  end

  function automatic logic m_irq();
    return |((m_sd | m_st | m_so) & m_en);
  endfunction

  function automatic logic [15:0] m_read(input logic [5:0] a);
    logic [15:0] v = '0;
    if (a[5]) begin
      case (a[1:0])
        2'd0: v = m_cmp[a[4:2]];
        2'd1: v = m_per[a[4:2]];
        2'd2: v = {15'd0, m_en[a[4:2]]};
        default: v = '0;
      endcase
    end else begin
      case (a)
        A_MODE:  v = {15'd0, m_mode};
        A_TLIM:  v = m_lim;
        A_SDONE: v = {8'd0, m_sd};
        A_STMO:  v = {8'd0, m_st};
        A_SOVR:  v = {8'd0, m_so};
        A_COUNT: v = m_cnt;
        default: v = '0;
      endcase
    end
    return v;
  endfunction

  function automatic string rtag(input logic [5:0] a);
    if (a == A_COUNT) return "R1 counter read";
    if (a[5] && a[1:0] == 2'd0) return "R3 compare read";
    if (a == A_SDONE || a == A_STMO || a == A_SOVR) return "R9 status read";
    return "R11 register read";
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: check outputs after the last edge, then drive the next inputs
  task automatic cyc(input logic w, input logic [5:0] a, input logic [15:0] d,
                     input logic [7:0] dn);
    @(negedge clk);
    check({8'd0, trig_o}, {8'd0, m_trig}, "R2 or R4 trigger output");
    check({15'd0, irq_o}, {15'd0, m_irq()}, "R10 interrupt");
    we = w; addr = a; wdata = d; done_i = dn;
    if (!w) begin
      #1;
      check(rdata, m_read(a), rtag(a));
    end
  endtask

  task automatic rnd_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      int r = $urandom % 16;
      logic [7:0] dn = 8'($urandom & $urandom & $urandom);
      if (r == 0)      cyc(1'b1, A_KICK, 16'($urandom % 256), dn);
      else if (r == 1) cyc(1'b1, 6'(3 + $urandom % 3), 16'($urandom % 256), dn);
      else             cyc(1'b0, 6'($urandom % 64), 16'd0, dn);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic [15:0] a0, c0;
    void'($urandom(32'd20240611));
    we = 0; addr = 0; wdata = 0; done_i = 0; rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R11: reset state
    check({8'd0, trig_o}, 16'd0, "R11 trigger after reset");
    check({15'd0, irq_o}, 16'd0, "R11 interrupt after reset");
    for (int k = 0; k < 6; k++) begin
      cyc(1'b0, 6'(k), 16'd0, 8'd0);
      check(rdata, 16'd0, "R11 register after reset");
    end

    // R1: counter advances one per clock
    cyc(1'b0, A_COUNT, 16'd0, 8'd0);
    a0 = rdata;
    repeat (10) cyc(1'b0, A_COUNT, 16'd0, 8'd0);
    check(rdata - a0, 16'd10, "R1 counter step");

    // manual mode configuration: enable every port but 3
    cyc(1'b1, A_TLIM, 16'd100, 8'd0);
    for (int p = 0; p < NP; p++)
      cyc(1'b1, 6'(34 + 4*p), (p == 3) ? 16'd0 : 16'd1, 8'd0);

    // R5: request to disabled port
    cyc(1'b1, A_KICK, 16'h0008, 8'd0);
    cyc(1'b0, A_SDONE, 16'd0, 8'd0);
    check({15'd0, trig_o[3]}, 16'd0, "R5 disabled port kicked");

    // R4 then R6: kick port 0, complete it
    cyc(1'b1, A_KICK, 16'h0001, 8'd0);
    cyc(1'b0, A_SDONE, 16'd0, 8'd0);
    check({15'd0, trig_o[0]}, 16'd1, "R4 manual kick");
    cyc(1'b0, A_SDONE, 16'd0, 8'h01);
    cyc(1'b0, A_SDONE, 16'd0, 8'd0);
    check(rdata, 16'h0001, "R6 completion sets done");
    check({15'd0, irq_o}, 16'd1, "R10 interrupt on done");
    cyc(1'b1, A_SDONE, 16'h0001, 8'd0);
    cyc(1'b0, A_SDONE, 16'd0, 8'h01);
    check(rdata, 16'h0000, "R9 write one clears");
    cyc(1'b0, A_SDONE, 16'd0, 8'd0);
    check(rdata, 16'h0000, "R6 stray completion ignored");

    // R7: timeout after L+1 cycles
    cyc(1'b1, A_TLIM, 16'd3, 8'd0);
    cyc(1'b1, A_KICK, 16'h0002, 8'd0);
    for (int k = 0; k < 4; k++) begin
      cyc(1'b0, A_STMO, 16'd0, 8'd0);
      check(rdata, 16'h0000, "R7 before expiry");
    end
    cyc(1'b0, A_STMO, 16'd0, 8'd0);
    check(rdata, 16'h0002, "R7 timeout expiry");

    // R7: completion in the expiry cycle wins
    cyc(1'b1, A_KICK, 16'h0010, 8'd0);
    repeat (3) cyc(1'b0, A_STMO, 16'd0, 8'd0);
    cyc(1'b0, A_STMO, 16'd0, 8'h10);
    cyc(1'b0, A_SDONE, 16'd0, 8'd0);
    check(rdata, 16'h0010, "R7 completion wins done");
    cyc(1'b0, A_STMO, 16'd0, 8'd0);
    check(rdata, 16'h0002, "R7 completion wins no timeout");

    // R8: second request while pending
    cyc(1'b1, A_TLIM, 16'd100, 8'd0);
    cyc(1'b1, A_KICK, 16'h0004, 8'd0);
    cyc(1'b1, A_KICK, 16'h0004, 8'd0);
    cyc(1'b0, A_SOVR, 16'd0, 8'd0);
    check(rdata, 16'h0004, "R8 overrun on request");
    check({15'd0, trig_o[2]}, 16'd0, "R8 dropped trigger");
    cyc(1'b1, A_SOVR, 16'h0004, 8'd0);
    cyc(1'b0, A_SOVR, 16'd0, 8'd0);
    check(rdata, 16'h0000, "R9 overrun cleared");

    // random manual traffic
    rnd_cycles(400);

    // operational configuration
    cyc(1'b1, A_TLIM, 16'd15, 8'd0);
    for (int p = 0; p < NP; p++) begin
      cyc(1'b1, 6'(33 + 4*p), (p == 0) ? 16'd50 : 16'(20 + $urandom % 60), 8'd0);
      cyc(1'b1, 6'(32 + 4*p), (p == 6) ? m_cnt + 16'd3000 : m_cnt + 16'(60 + 9*p), 8'd0);
    end
    cyc(1'b1, A_MODE, 16'd1, 8'd0);
    c0 = m_cmp[0];

    // R3: compare advances by period on match
    for (int k = 0; k < 200; k++) begin
      cyc(1'b0, 6'h20, 16'd0, 8'd0);
      if (trig_o[0]) break;
    end
    check(rdata, c0 + 16'd50, "R3 compare advanced");

    // R4: requests ignored in operational mode
    cyc(1'b1, A_KICK, 16'h0040, 8'd0);
    cyc(1'b0, A_SOVR, 16'd0, 8'd0);
    check({15'd0, trig_o[6]}, 16'd0, "R4 kick ignored in operational mode");

    rnd_cycles(3000);

    // R8: timer overrun with short period and long timeout
    cyc(1'b1, A_TLIM, 16'd30, 8'd0);
    cyc(1'b1, 6'h3D, 16'd5, 8'd0);
    cyc(1'b1, 6'h3C, m_cnt + 16'd3, 8'd0);
    repeat (20) cyc(1'b0, A_SOVR, 16'd0, 8'd0);
    check(rdata & 16'h0080, 16'h0080, "R8 timer overrun");

    // R5 and R10: disable all ports, status left set
    for (int p = 0; p < NP; p++) cyc(1'b1, 6'(34 + 4*p), 16'd0, 8'd0);
    for (int k = 0; k < 100; k++) begin
      cyc(1'b0, A_COUNT, 16'd0, 8'($urandom));
      check({8'd0, trig_o}, 16'd0, "R5 disabled ports silent");
      check({15'd0, irq_o}, 16'd0, "R10 interrupt masked");
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule